// File: doc/BRIEF.md
# Card Command Issuer

This block sends one command at a time to a memory card and captures what the card returns. Host logic loads a 32-bit argument and then an 11-bit command word. Writing the command word with its start flag set launches a transaction on a small card-side handshake. The block raises a request that carries the command index and the argument. The card answers with a one-cycle acknowledge that gives a byte count, and then sends that many reply bytes, one per valid cycle.

The block checks whether the reply length is allowed for the flags in the command word. It packs the bytes into four 32-bit response words and reports the outcome through exactly one of three status bits: response received, command sent without response, or command timeout. Response words change only when a reply is accepted. The start flag drops by itself when the transaction ends.

If the card stays silent for too long, the block stops waiting. A missing acknowledge is treated as a zero-byte reply, and a reply that stalls partway through is treated as a timeout.

Top module: `card_cmd_issuer`

## Requirements
- R1: The command word is 11 bits with the following fields.
  - Bits 5:0 hold the command index, which is presented on `card_index_o` during the request.
  - Bit 6 means a response is expected.
  - Bit 7 means a long response is requested.
  - Bits 8 and 9 are stored and read back on `cmd_o` but have no other effect.
  - Bit 10 is the start flag.
- R2: Writing the command word with bit 10 set while the block is idle sets `busy_o` and `card_req_o` in the next cycle. Writing it with bit 10 clear only stores the word.
- R3: A write to the command word while `busy_o` is high is ignored. `cmd_o` keeps its value and no second transaction starts.
- R4: When bit 6 is clear, the transaction ends with `status_o` equal to 8'h80 (bit 7, command sent). This holds whatever byte count the card reports, and also when the card never acknowledges.
- R5: When bit 6 is set and bit 7 is clear, a 4-byte reply is accepted and `status_o` becomes 8'h40 (bit 6). The bytes are packed big-endian, so the first byte lands in bits 31:24 of response word 0. Response words 1 to 3 become zero.
- R6: When bit 6 is set, a 16-byte reply is accepted whether or not bit 7 is set. Byte k lands in word k/4 at bits 31-8*(k%4) down to 24-8*(k%4). Bit 0 of word 3 is forced to zero, and `status_o` becomes 8'h40.
- R7: When bit 6 is set, each of the following ends the transaction with `status_o` equal to 8'h04 (bit 2, command timeout) and leaves all four response words unchanged:
  - a byte count of 0;
  - a byte count of 4 while bit 7 is set;
  - any byte count other than 4 or 16.
- R8: With no acknowledge, the transaction ends after `TIMEOUT_CYCLES` busy cycles and is treated as a zero-byte reply. The same limit applies between reply bytes. A reply that stalls partway through ends with status 8'h04.
- R9: When a transaction starts, all three status bits clear, and at most one of them is ever set. When the transaction ends, bit 10 of `cmd_o` clears and `busy_o` falls, whatever the outcome.
- R10: After reset, the command word, the argument, the status, all response words, `busy_o` and `card_req_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_i | input | 1 | Register write strobe |
| host_sel_i | input | 1 | Write target: 0 selects the argument, 1 selects the command word |
| host_wdata_i | input | 32 | Write data |
| cmd_o | output | 11 | Stored command word |
| busy_o | output | 1 | Transaction in progress |
| status_o | output | 8 | Outcome bits: 2 = timeout, 6 = response received, 7 = sent without response |
| resp0_o | output | 32 | Response word 0 |
| resp1_o | output | 32 | Response word 1 |
| resp2_o | output | 32 | Response word 2 |
| resp3_o | output | 32 | Response word 3 |
| card_req_o | output | 1 | Request to the card, held until acknowledge or timeout |
| card_index_o | output | 6 | Command index sent to the card |
| card_arg_o | output | 32 | Command argument sent to the card |
| card_ack_i | input | 1 | One-cycle acknowledge from the card |
| card_len_i | input | 5 | Reply byte count, valid with the acknowledge |
| card_byte_vld_i | input | 1 | Reply byte valid |
| card_byte_i | input | 8 | Reply byte |

## Verification
The bench checks byte order and the forced low bit of word 3. A design that packs bytes little-endian, or copies that bit through, returns response words with the wrong value. It also checks that a short reply after a long one clears words 1 to 3; a design that skips this keeps stale data. Three lengths are rejected: zero, four bytes under the long flag, and eight bytes. For each, the bench checks that the timeout bit is set and that the response words are untouched, so a design that commits bytes before validating the reply is caught. Finally, the bench counts the busy cycles in a silent transaction, writes to the command word while the block is busy, and stalls a reply partway through. These catch an off-by-one timeout, a command word that is overwritten or restarted during a transaction, and a reply that never ends.

// File: rtl/card_cmd_pkg.sv
// Package: shared field positions, sizes and the sequencer state type
// for the card command issuer. Assumes an 11-bit command word.
package card_cmd_pkg;

    localparam int CMD_W        = 11;
    localparam int IDX_W        = 6;
    localparam int BIT_RESP     = 6;
    localparam int BIT_LONG     = 7;
    localparam int BIT_START    = 10;

    localparam int STAT_W       = 8;
    localparam int STAT_TIMEOUT = 2;
    localparam int STAT_RESPEND = 6;
    localparam int STAT_SENT    = 7;

    localparam int SHORT_BYTES  = 4;
    localparam int LONG_BYTES   = 16;
    localparam int WORDS        = LONG_BYTES / 4;
    localparam int LEN_W        = $clog2(LONG_BYTES + 1);
    localparam int BIDX_W       = $clog2(LONG_BYTES);

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_REQ    = 2'd1,
        SEQ_RECV   = 2'd2,
        SEQ_COMMIT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ccmd_word_reg.sv
// Command word register and field decode.
// Stores the command word on a host write when idle, ignores writes while
// a transaction runs, and clears the start flag when the sequencer signals
// completion. Assumes done_i is only asserted while busy_i is high.
module ccmd_word_reg
    import card_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [31:0]       wdata_i,
    input  logic              busy_i,
    input  logic              done_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              start_o,
    output logic [IDX_W-1:0]  index_o,
    output logic              resp_exp_o,
    output logic              long_o
);

    logic [CMD_W-1:0] cmd_q;

    // Accepting write: only while idle
    logic wr_ok;
    assign wr_ok   = wr_i && !busy_i;
    assign start_o = wr_ok && wdata_i[BIT_START];

    // Hold the command word; self-clear the start flag on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_ok) begin
            cmd_q <= wdata_i[CMD_W-1:0];
        end else if (done_i) begin
            cmd_q[BIT_START] <= 1'b0;
        end
    end

    // Field decode from the stored word
    assign cmd_o      = cmd_q;
    assign index_o    = cmd_q[IDX_W-1:0];
    assign resp_exp_o = cmd_q[BIT_RESP];
    assign long_o     = cmd_q[BIT_LONG];

    // R3: a write during a transaction leaves the word untouched
    p_busy_write_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && busy_i && !done_i) |=> $stable(cmd_o));

endmodule

// File: rtl/ccmd_timer.sv
// Silence timer: counts cycles while run_i is high without an event.
// expired_o rises in the LIMIT-th such cycle. kick_i or a low run_i
// restarts the count. Assumes LIMIT >= 2.
module ccmd_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    // Count silent cycles, restart on event or when not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || kick_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the count never passes the limit
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/ccmd_reply_pack.sv
// Reply byte packer: one byte register per slot of a long reply, written
// by index, read out as big-endian words (slot 0 in bits 31:24 of word 0).
// Assumes the index stays below the slot count while wr_i is high.
module ccmd_reply_pack
    import card_cmd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [BIDX_W-1:0]       idx_i,
    input  logic [7:0]              byte_i,
    output logic [WORDS*32-1:0]     words_o
);

    for (genvar k = 0; k < LONG_BYTES; k++) begin : g_slot
        localparam int POS = 32 * (k / 4) + 24 - 8 * (k % 4);
        logic [7:0] slot_q;

        // Capture the byte addressed to this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_i && (idx_i == BIDX_W'(k))) begin
                slot_q <= byte_i;
            end
        end

        assign words_o[POS +: 8] = slot_q;
    end

endmodule

// File: rtl/card_cmd_issuer.sv
// Card command issuer top: argument register, transaction sequencer,
// reply length checks, response word commit and status bits.
// Assumes the card gives one acknowledge per request and then sends exactly
// the reported number of bytes; bytes arriving while idle are dropped.
module card_cmd_issuer
    import card_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic              host_sel_i,
    input  logic [31:0]       host_wdata_i,
    output logic [10:0]       cmd_o,
    output logic              busy_o,
    output logic [7:0]        status_o,
    output logic [31:0]       resp0_o,
    output logic [31:0]       resp1_o,
    output logic [31:0]       resp2_o,
    output logic [31:0]       resp3_o,
    output logic              card_req_o,
    output logic [5:0]        card_index_o,
    output logic [31:0]       card_arg_o,
    input  logic              card_ack_i,
    input  logic [4:0]        card_len_i,
    input  logic              card_byte_vld_i,
    input  logic [7:0]        card_byte_i
);

    seq_state_t        state_q;
    logic [31:0]       arg_q;
    logic [LEN_W-1:0]  expect_q;
    logic [BIDX_W-1:0] bcnt_q;
    logic              long_reply_q;
    logic              st_timeout_q, st_respend_q, st_sent_q;
    logic [31:0]       resp_q [WORDS];

    logic              start, done, expired, resp_exp, long_flag;
    logic              len_short_ok, len_long_ok, last_byte;
    logic [WORDS*32-1:0] packed_words;

    assign busy_o = (state_q != SEQ_IDLE);

    // Command word register and decode
    ccmd_word_reg u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (host_wr_i && host_sel_i),
        .wdata_i    (host_wdata_i),
        .busy_i     (busy_o),
        .done_i     (done),
        .cmd_o      (cmd_o),
        .start_o    (start),
        .index_o    (card_index_o),
        .resp_exp_o (resp_exp),
        .long_o     (long_flag)
    );

    // Silence timer for acknowledge and inter-byte gaps
    ccmd_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == SEQ_REQ || state_q == SEQ_RECV),
        .kick_i    ((state_q == SEQ_REQ && card_ack_i) ||
                    (state_q == SEQ_RECV && card_byte_vld_i)),
        .expired_o (expired)
    );

    // Shadow byte store for the reply in flight
    ccmd_reply_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (state_q == SEQ_RECV && card_byte_vld_i),
        .idx_i   (bcnt_q),
        .byte_i  (card_byte_i),
        .words_o (packed_words)
    );

    // Argument register, writable any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
        end else if (host_wr_i && !host_sel_i) begin
            arg_q <= host_wdata_i;
        end
    end

    assign card_arg_o = arg_q;
    assign card_req_o = (state_q == SEQ_REQ);

    // Reply length acceptance for the current flags
    assign len_short_ok = (card_len_i == 5'(SHORT_BYTES)) && !long_flag;
    assign len_long_ok  = (card_len_i == 5'(LONG_BYTES));
    assign last_byte    = ({1'b0, bcnt_q} == expect_q - 1'b1);

    // Completion: the sequencer returns to idle at the next edge
    always_comb begin
        done = 1'b0;
        unique case (state_q)
            SEQ_REQ:    done = card_ack_i ? !(resp_exp && (len_short_ok || len_long_ok))
                                          : expired;
            SEQ_RECV:   done = !card_byte_vld_i && expired;
            SEQ_COMMIT: done = 1'b1;
            default:    done = 1'b0;
        endcase
    end

    // Transaction sequencer with status and response commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            expect_q     <= '0;
            bcnt_q       <= '0;
            long_reply_q <= 1'b0;
            st_timeout_q <= 1'b0;
            st_respend_q <= 1'b0;
            st_sent_q    <= 1'b0;
            for (int w = 0; w < WORDS; w++) resp_q[w] <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q      <= SEQ_REQ;
                        st_timeout_q <= 1'b0;
                        st_respend_q <= 1'b0;
                        st_sent_q    <= 1'b0;
                    end
                end
                SEQ_REQ: begin
                    if (card_ack_i) begin
                        if (!resp_exp) begin
                            st_sent_q <= 1'b1;
                            state_q   <= SEQ_IDLE;
                        end else if (len_short_ok || len_long_ok) begin
                            expect_q     <= LEN_W'(card_len_i);
                            long_reply_q <= len_long_ok;
                            bcnt_q       <= '0;
                            state_q      <= SEQ_RECV;
                        end else begin
                            st_timeout_q <= 1'b1;
                            state_q      <= SEQ_IDLE;
                        end
                    end else if (expired) begin
                        st_timeout_q <= resp_exp;
                        st_sent_q    <= !resp_exp;
                        state_q      <= SEQ_IDLE;
                    end
                end
                SEQ_RECV: begin
                    if (card_byte_vld_i) begin
                        if (last_byte) state_q <= SEQ_COMMIT;
                        else           bcnt_q  <= bcnt_q + 1'b1;
                    end else if (expired) begin
                        st_timeout_q <= 1'b1;
                        state_q      <= SEQ_IDLE;
                    end
                end
                SEQ_COMMIT: begin
                    for (int w = 0; w < WORDS; w++) begin
                        if (w == 0 || long_reply_q) resp_q[w] <= packed_words[32*w +: 32];
                        else                        resp_q[w] <= '0;
                    end
                    if (long_reply_q) resp_q[WORDS-1][0] <= 1'b0;
                    st_respend_q <= 1'b1;
                    state_q      <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output assembly
    always_comb begin
        status_o               = '0;
        status_o[STAT_TIMEOUT] = st_timeout_q;
        status_o[STAT_RESPEND] = st_respend_q;
        status_o[STAT_SENT]    = st_sent_q;
    end

    assign resp0_o = resp_q[0];
    assign resp1_o = resp_q[1];
    assign resp2_o = resp_q[2];
    assign resp3_o = resp_q[3];

    // R2: a start is followed by a request to the card
    p_start_requests_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> card_req_o);

    // R9: the start flag is clear whenever the block goes idle
    p_start_flag_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !cmd_o[BIT_START]);

    // R9: never more than one outcome bit
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_timeout_q, st_respend_q, st_sent_q}) <= 1);

    // R5: a short reply zeroes the upper response words
    p_short_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_COMMIT && !long_reply_q) |=>
            (resp1_o == '0 && resp2_o == '0 && resp3_o == '0));

    // R6: a long reply has bit 0 of word 3 low
    p_long_lsb_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_COMMIT && long_reply_q) |=> !resp3_o[0]);

    // R7: a timeout never alters the response words
    p_timeout_keeps_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_timeout_q) |-> ($stable(resp0_o) && $stable(resp3_o)));

endmodule

// File: tb/card_cmd_issuer_bench.sv
// Directed bench for card_cmd_issuer: one task per scenario.
module card_cmd_issuer_bench;

    localparam int TMO   = 16;
    localparam logic [31:0] F_RESP  = 32'h40;
    localparam logic [31:0] F_LONG  = 32'h80;
    localparam logic [31:0] F_START = 32'h400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_sel;
    logic [31:0] host_wdata;
    logic [10:0] cmd_o;
    logic        busy_o;
    logic [7:0]  status_o;
    logic [31:0] resp0_o, resp1_o, resp2_o, resp3_o;
    logic        card_req_o;
    logic [5:0]  card_index_o;
    logic [31:0] card_arg_o;
    logic        card_ack;
    logic [4:0]  card_len;
    logic        card_vld;
    logic [7:0]  card_byte;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    card_cmd_issuer #(.TIMEOUT_CYCLES(TMO)) u_card_cmd_issuer (
        .clk (clk), .rst_n (rst_n),
        .host_wr_i (host_wr), .host_sel_i (host_sel), .host_wdata_i (host_wdata),
        .cmd_o (cmd_o), .busy_o (busy_o), .status_o (status_o),
        .resp0_o (resp0_o), .resp1_o (resp1_o), .resp2_o (resp2_o), .resp3_o (resp3_o),
        .card_req_o (card_req_o), .card_index_o (card_index_o), .card_arg_o (card_arg_o),
        .card_ack_i (card_ack), .card_len_i (card_len),
        .card_byte_vld_i (card_vld), .card_byte_i (card_byte)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic card_answer(input logic [4:0] len, input int nbytes, input logic [7:0] base);
        card_ack = 1'b1; card_len = len;
        @(negedge clk);
        card_ack = 1'b0; card_len = '0;
        for (int k = 0; k < nbytes; k++) begin
            card_vld = 1'b1; card_byte = base + 8'(k);
            @(negedge clk);
        end
        card_vld = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_o && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [31:0] expw(input logic [7:0] base, input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) r = {r[23:0], base + 8'(4 * w + k)};
        return r;
    endfunction

    task automatic t_reset;
        chk("R10", "cmd", 32'(cmd_o), 0);
        chk("R10", "status", 32'(status_o), 0);
        chk("R10", "busy/req", {30'd0, busy_o, card_req_o}, 0);
        chk("R10", "resp or", resp0_o | resp1_o | resp2_o | resp3_o, 0);
        chk("R10", "arg", card_arg_o, 0);
    endtask

    task automatic t_store_only;
        host_write(1'b1, 32'h0000_0003 | F_RESP);
        @(negedge clk);
        chk("R2", "busy without start", 32'(busy_o), 0);
        chk("R2", "req without start", 32'(card_req_o), 0);
        chk("R2", "stored word", 32'(cmd_o), 32'h43);
    endtask

    task automatic t_no_response;
        int cyc;
        logic [31:0] c = 32'h0A | 32'h300 | F_START;
        host_write(1'b0, 32'hCAFE_0001);
        host_write(1'b1, c);
        chk("R2", "req after start", {30'd0, busy_o, card_req_o}, 3);
        chk("R1", "index to card", 32'(card_index_o), 32'h0A);
        chk("R1", "arg to card", card_arg_o, 32'hCAFE_0001);
        chk("R1", "flags 8/9 stored", 32'(cmd_o), c);
        card_answer(5'd4, 0, 8'h00);
        wait_idle(cyc);
        chk("R4", "status sent", 32'(status_o), 32'h80);
        chk("R9", "start flag cleared", 32'(cmd_o), c & ~F_START);
    endtask

    task automatic t_no_response_silent;
        int cyc;
        host_write(1'b1, 32'h01 | F_START);
        wait_idle(cyc);
        chk("R4", "silent no-resp sent", 32'(status_o), 32'h80);
        chk("R8", "silent no-resp cycles", 32'(cyc), 32'(TMO));
    endtask

    task automatic t_long;
        int cyc;
        host_write(1'b1, 32'h02 | F_RESP | F_LONG | F_START);
        card_answer(5'd16, 16, 8'hF0);
        wait_idle(cyc);
        chk("R6", "status", 32'(status_o), 32'h40);
        chk("R6", "word0", resp0_o, expw(8'hF0, 0));
        chk("R6", "word1", resp1_o, expw(8'hF0, 1));
        chk("R6", "word2", resp2_o, expw(8'hF0, 2));
        chk("R6", "word3 lsb forced", resp3_o, expw(8'hF0, 3) & ~32'h1);
    endtask

    task automatic t_short;
        int cyc;
        host_write(1'b1, 32'h11 | F_RESP | F_START);
        chk("R9", "status cleared on start", 32'(status_o), 0);
        card_answer(5'd4, 4, 8'hA1);
        wait_idle(cyc);
        chk("R5", "status", 32'(status_o), 32'h40);
        chk("R5", "word0 big-endian", resp0_o, 32'hA1A2A3A4);
        chk("R5", "words1-3 zero", resp1_o | resp2_o | resp3_o, 0);
    endtask

    task automatic t_sixteen_no_long;
        int cyc;
        host_write(1'b1, 32'h12 | F_RESP | F_START);
        card_answer(5'd16, 16, 8'h30);
        wait_idle(cyc);
        chk("R6", "16 without long flag status", 32'(status_o), 32'h40);
        chk("R6", "16 without long flag word3", resp3_o, 32'h3C3D3E3E);
    endtask

    task automatic bad_len(input logic [31:0] flags, input logic [4:0] len, input int nb,
                           input string what);
        int cyc;
        host_write(1'b1, 32'h05 | flags | F_START);
        card_answer(len, nb, 8'h55);
        wait_idle(cyc);
        chk("R7", {what, " status"}, 32'(status_o), 32'h04);
        chk("R7", {what, " word0 kept"}, resp0_o, expw(8'h30, 0));
        chk("R7", {what, " word3 kept"}, resp3_o, 32'h3C3D3E3E);
    endtask

    task automatic t_bad_lengths;
        bad_len(F_RESP | F_LONG, 5'd4, 4, "short under long flag");
        bad_len(F_RESP, 5'd0, 0, "zero length");
        bad_len(F_RESP, 5'd8, 8, "length 8");
    endtask

    task automatic t_timeout;
        int cyc;
        host_write(1'b1, 32'h06 | F_RESP | F_START);
        wait_idle(cyc);
        chk("R8", "silent busy cycles", 32'(cyc), 32'(TMO));
        chk("R8", "silent status", 32'(status_o), 32'h04);
        chk("R9", "start flag cleared on timeout", 32'(cmd_o[10]), 0);
    endtask

    task automatic t_midstream;
        int cyc;
        host_write(1'b1, 32'h07 | F_RESP | F_START);
        card_answer(5'd4, 2, 8'h99);
        wait_idle(cyc);
        chk("R8", "stalled reply status", 32'(status_o), 32'h04);
        chk("R7", "stalled reply word0 kept", resp0_o, expw(8'h30, 0));
    endtask

    task automatic t_busy_write;
        int cyc;
        logic [31:0] c = 32'h09 | F_RESP | F_START;
        host_write(1'b1, c);
        host_write(1'b1, 32'h3F | F_LONG | F_START);
        chk("R3", "word during busy", 32'(cmd_o), c);
        chk("R3", "index during busy", 32'(card_index_o), 32'h09);
        card_answer(5'd4, 4, 8'h61);
        wait_idle(cyc);
        repeat (3) @(negedge clk);
        chk("R3", "no second start", 32'(busy_o), 0);
        chk("R3", "word after", 32'(cmd_o), c & ~F_START);
        chk("R5", "word0 after busy write", resp0_o, 32'h61626364);
    endtask

    initial begin
        rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
        card_ack = 1'b0; card_len = '0; card_vld = 1'b0; card_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_store_only;
        t_no_response;
        t_no_response_silent;
        t_long;
        t_short;
        t_sixteen_no_long;
        t_bad_lengths;
        t_timeout;
        t_midstream;
        t_busy_write;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule